// File: doc/BRIEF.md
# Skip and Two-Word Fetch Sequencer

This block steers instruction fetch in a two-stage fetch/execute core with 16-bit instruction words. Each cycle it presents a byte fetch address and takes back the word stored there. That word is latched into the execute slot for the next cycle. While an instruction sits in execute, the block applies its effect on program flow. A relative branch, a taken conditional branch or an absolute two-word jump or call loads a new fetch address and flushes the one wrong-path word already fetched. A skip whose condition holds discards the following instruction. When that instruction is two words long, both of its words are discarded.

The surrounding core evaluates skip and branch conditions and supplies them as two level inputs, `skip_hit` and `br_take`, which refer to the word shown on `ex_word`. Branch offsets and jump targets come from the instruction words themselves. The block marks every discarded or meaningless execute slot with `ex_nop`. The datapath must treat such a slot as a no-operation. Stack and interrupt handling are outside this block.

Top module: `skip_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `fetch_addr` is 0 and `ex_nop` is 1.
- R2: In a cycle with no redirect, `fetch_addr` rises by 2 on each clock, and `ex_word` shows the word that was fetched in the previous cycle.
- R3: When `skip_hit` is 1 in a live slot (`ex_nop`=0) and the next instruction is one word long, exactly one following slot has `ex_nop`=1. The fetch address keeps advancing by 2 throughout.
- R4: When the skipped instruction is two words long, the next two slots both have `ex_nop`=1. A first word counts as two-word when it starts with 1100, 1110 1111, 1110 110x or 1110 1110 00.
- R5: A word starting with 1111 always has `ex_nop`=1 in execute, even when it is reached in sequence.
- R6: A live word 1101 xnnn nnnn nnnn (relative branch or call) sets the next `fetch_addr` to the current `fetch_addr` plus twice the 11-bit signed offset n. The slot that follows has `ex_nop`=1.
- R7: A live word 1110 0ccc nnnn nnnn with `br_take`=1 sets the next `fetch_addr` to the current `fetch_addr` plus twice the 8-bit signed offset. The slot that follows has `ex_nop`=1. With `br_take`=0 the address advances by 2 and nothing is discarded.
- R8: A live absolute jump or call (1110 1111 or 1110 110x, low byte L), with the word at the current fetch address being 1111 H (12-bit H), sets the next `fetch_addr` to {H, L, 0}. The slot that follows has `ex_nop`=1.
- R9: `skip_hit` and `br_take` have no effect while `ex_nop`=1. The fetch address advances by 2, and the next slot is not discarded unless some other rule discards it.
- R10: A two-word first word that is flushed by a branch discards only itself. The instruction at the branch target executes with `ex_nop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_word | input | 16 | Program word stored at `fetch_addr` |
| skip_hit | input | 1 | Word in execute is a skip and its condition holds |
| br_take | input | 1 | Condition of the conditional branch in execute holds |
| fetch_addr | output | ADDR_W | Byte address being fetched |
| ex_word | output | 16 | Word in the execute slot |
| ex_nop | output | 1 | Execute slot must behave as a no-operation |

## Verification
Properties are checked on every clock. They cover the following:
- an orphan 1111 word always being a no-operation;
- a live skip, a taken conditional branch, a relative branch and an absolute jump always discarding the next slot;
- the exact relative-branch target arithmetic;
- address advance by 2 in every cycle without a redirect, including killed slots where `skip_hit` or `br_take` is raised.

Other behaviours depend on what the program contains, so only the bench scenarios show them. These are the slot count of a discard (one versus two words), the absolute target assembled from two words, and the rule that a flushed two-word word does not extend the discard.

// File: rtl/skip_seq.sv
module skip_seq #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       fetch_word,
  input  logic              skip_hit,
  input  logic              br_take,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [15:0]       ex_word,
  output logic              ex_nop
);
  localparam int JMP_W = 21;

  logic [ADDR_W-1:0] pc_q, pc_d, rel_off, bcc_off;
  logic [JMP_W-1:0]  jmp_tgt;
  logic [15:0]       ir_q;
  logic              ir_2w_q, flush_q, skip_q, skip2_q;

  function automatic logic first_of_two(input logic [15:0] w);
    return (w[15:8] == 8'hEF) || (w[15:9] == 7'b1110110) ||
           (w[15:12] == 4'hC) || (w[15:6] == 10'b1110111000);
  endfunction

  wire orphan = (ir_q[15:12] == 4'hF);
  wire live   = !(flush_q || skip_q || skip2_q || orphan);

  wire do_rel  = live && (ir_q[15:12] == 4'hD);
  wire do_bcc  = live && (ir_q[15:11] == 5'b11100) && br_take;
  wire do_abs  = live && ((ir_q[15:8] == 8'hEF) || (ir_q[15:9] == 7'b1110110));
  wire do_skip = live && skip_hit;

  assign rel_off = {{(ADDR_W-12){ir_q[10]}}, ir_q[10:0], 1'b0};
  assign bcc_off = {{(ADDR_W-9){ir_q[7]}}, ir_q[7:0], 1'b0};
  assign jmp_tgt = {fetch_word[11:0], ir_q[7:0], 1'b0};

  always_comb begin
    if (do_abs)      pc_d = ADDR_W'(jmp_tgt);
    else if (do_rel) pc_d = pc_q + rel_off;
    else if (do_bcc) pc_d = pc_q + bcc_off;
    else             pc_d = pc_q + ADDR_W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ir_q    <= '0;
      ir_2w_q <= 1'b0;
      flush_q <= 1'b1;
      skip_q  <= 1'b0;
      skip2_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      ir_q    <= fetch_word;
      ir_2w_q <= first_of_two(fetch_word);
      flush_q <= do_abs || do_rel || do_bcc;
      skip_q  <= do_skip;
      skip2_q <= skip_q && ir_2w_q;
    end
  end

  assign fetch_addr = pc_q;
  assign ex_word    = ir_q;
  assign ex_nop     = !live;
endmodule

module skip_seq_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       fetch_word,
  input logic              skip_hit,
  input logic              br_take,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [15:0]       ex_word,
  input logic              ex_nop
);
  wire is_rel = ex_word[15:12] == 4'hD;
  wire is_bcc = ex_word[15:11] == 5'b11100;
  wire is_abs = (ex_word[15:8] == 8'hEF) || (ex_word[15:9] == 7'b1110110);

  // R5
  orphan_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_word[15:12] == 4'hF |-> ex_nop);

  // R3
  skip_kills_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_nop && skip_hit |=> ex_nop);

  // R6
  rel_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_nop && is_rel |=> ex_nop &&
      fetch_addr == $past(fetch_addr) + {{(ADDR_W-12){$past(ex_word[10])}}, $past(ex_word[10:0]), 1'b0});

  // R7
  bcc_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_nop && is_bcc && br_take |=> ex_nop);

  // R8
  abs_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_nop && is_abs |=> ex_nop);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_nop && !is_rel && !is_abs && !(is_bcc && br_take) |=>
      fetch_addr == $past(fetch_addr) + ADDR_W'(2));

  // R9
  dead_slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_nop |=> fetch_addr == $past(fetch_addr) + ADDR_W'(2));
endmodule

bind skip_seq skip_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_skip_seq.sv
`timescale 1ns/1ps
module sim_skip_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fetch_word;
  logic        skip_hit, br_take;
  logic [20:0] fetch_addr;
  logic [15:0] ex_word;
  logic        ex_nop;
  logic [15:0] mem [64];
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  assign fetch_word = mem[fetch_addr[6:1]];
  assign skip_hit   = (ex_word[15:8] == 8'h66);
  assign br_take    = (ex_word[15:11] == 5'b11100) && ex_word[8];

  skip_seq u0 (.clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .skip_hit(skip_hit),
               .br_take(br_take), .fetch_addr(fetch_addr), .ex_word(ex_word), .ex_nop(ex_nop));

  // {ex_nop, fetch_addr} per cycle after reset release for program A
  localparam logic [21:0] TRACE [25] = '{
    {1'b1, 21'h00}, {1'b0, 21'h02}, {1'b0, 21'h04}, {1'b1, 21'h06}, {1'b0, 21'h08},
    {1'b1, 21'h0A}, {1'b1, 21'h0C}, {1'b0, 21'h0E}, {1'b0, 21'h10}, {1'b1, 21'h12},
    {1'b0, 21'h14}, {1'b1, 21'h1A}, {1'b0, 21'h1C}, {1'b1, 21'h1E}, {1'b0, 21'h20},
    {1'b0, 21'h22}, {1'b1, 21'h40}, {1'b0, 21'h42}, {1'b1, 21'h3E}, {1'b0, 21'h40},
    {1'b1, 21'h42}, {1'b0, 21'h44}, {1'b1, 21'h4E}, {1'b0, 21'h50}, {1'b0, 21'h52}};

  function automatic string tag_of(input int i);
    case (i)
      0: return "R1";
      3: return "R3";
      5, 6: return "R4";
      9: return "R5";
      11: return "R6";
      12, 13: return "R9";
      14: return "R7";
      16: return "R8";
      17, 18: return "R6";
      20: return "R3";
      22, 23: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step();
    chk("R1", {11'd0, fetch_addr}, 32'h0);
    chk("R1", {31'd0, ex_nop}, 32'h1);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0E00;
    mem[0]  = 16'h0E05; mem[1]  = 16'h6601; mem[2]  = 16'h0E01; mem[3]  = 16'h6601;
    mem[4]  = 16'hC123; mem[5]  = 16'hF456; mem[6]  = 16'h6201; mem[7]  = 16'h0E02;
    mem[8]  = 16'hF000; mem[9]  = 16'hD003; mem[10] = 16'hE1FF; mem[13] = 16'hE101;
    mem[14] = 16'h6601; mem[15] = 16'hE002; mem[16] = 16'hEF20; mem[17] = 16'hF000;
    mem[31] = 16'h6601; mem[32] = 16'hD7FE; mem[33] = 16'hD005; mem[34] = 16'hEF00;
    mem[39] = 16'h0E07;
    repeat (3) @(posedge clk);
    do_reset();
    for (int i = 0; i < 25; i++) begin
      chk(tag_of(i), {10'd0, TRACE[i]}, {10'd0, ex_nop, fetch_addr});
      if (i == 1) chk("R2", {16'd0, ex_word}, 32'h0E05);
      if (i == 13) chk("R9", {16'd0, ex_word}, 32'h6601);
      if (i < 24) step();
    end

    // program B: skip over a pointer-load pair, then an absolute call with high bits
    for (int i = 0; i < 64; i++) mem[i] = 16'h0E00;
    mem[0] = 16'h6601; mem[1] = 16'hEE05; mem[2] = 16'hF000; mem[3] = 16'h0E01;
    mem[4] = 16'hEC34; mem[5] = 16'hFABC;
    do_reset();
    step();
    chk("R2", {31'd0, ex_nop}, 32'h0);
    step();
    chk("R4", {31'd0, ex_nop}, 32'h1);
    step();
    chk("R4", {31'd0, ex_nop}, 32'h1);
    step();
    chk("R4", {15'd0, ex_word, ex_nop}, {15'd0, 16'h0E01, 1'b0});
    step();
    chk("R8", {15'd0, ex_word, ex_nop}, {15'd0, 16'hEC34, 1'b0});
    step();
    chk("R8", {11'd0, fetch_addr}, 32'h157868);
    chk("R8", {31'd0, ex_nop}, 32'h1);
    step();
    chk("R2", {11'd0, fetch_addr}, 32'h15786A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule